// File: doc/BRIEF.md
# Center-Aligned Two-Channel PWM Time Base

This block produces two pulse-width-modulated signals from one triangle counter. The counter climbs from zero to a programmable top value and falls back to zero. Each output has its own compare value. When the counter meets that compare value, the output responds, and the response depends on whether the counter is rising or falling at that moment. With the default actions the resulting pulse is centred on the counter's zero point, and the duty cycle equals compare divided by top.

Software writes the top value and both compare values through a small register port. Those writes land in holding (shadow) registers. The working copies take the new values only at the counter's zero point, so a pulse that is already under way is never disturbed. A fourth register holds the per-channel edge actions and a phase-load enable. These take effect at once.

Every time the counter passes zero, the block emits a one-cycle pulse on its sync output. A second instance can take that pulse on its sync input. If phase loading is enabled, the second instance reloads its counter with a phase value and counts upward from there. Its triangle then follows the first instance at a fixed offset.

Top module: `tri_pwm`

## Requirements
- R1: The counter steps by exactly one each cycle. It turns downward at the top value and upward at zero, so one full triangle takes 2×top cycles. The sync output is high for one cycle per triangle, which gives an interval of 2×top cycles between pulses.
- R2: The register addresses are 0 for top, 1 for compare A and 2 for compare B. A write to any of them goes into a holding register. The working value takes the held value at the first cycle in which the counter is zero.
- R3: A write made while the counter is not zero leaves the triangle in progress unchanged. The current pulse keeps its old width.
- R4: With the default actions, a rising-count match drives the output low and a falling-count match drives it high. For a compare value C, each triangle therefore has 2×top−2×C low cycles in one contiguous run centred on the top.
- R5: A compare equal to top keeps the output high for the whole triangle. A compare of zero keeps it low for the whole triangle.
- R6: A write made in the same cycle as a zero-point transfer is held. It takes effect only at the following zero point, which is one full triangle later.
- R7: A new top value leaves the current triangle's length unchanged and applies from the next triangle onward.
- R8: In reset both outputs and the sync output are low. Top resets to PER_RST (default 10), both compares reset to 0, and the control register resets to 0x099.
- R9: Control register (address 3) fields use the codes 0 = hold, 1 = drive low, 2 = drive high, 3 = toggle. The fields are: bits [1:0] for A on a rising-count match, [3:2] for A on a falling-count match, [5:4] for B rising, [7:6] for B falling, and bit 8 for phase-load enable. A match at zero counts as rising and a match at top counts as falling.
- R10: When bit 8 is set and sync_in is high, the counter loads phase_val at the next edge and then counts up. With phase_val = 2, a slave fed by a master's sync output runs with the same sync and outputs as the master.
- R11: When bit 8 is clear, sync_in is ignored and the counter keeps its own timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 top, 1 compare A, 2 compare B, 3 control) |
| wr_data | input | CNT_W | Register write data |
| phase_val | input | CNT_W | Counter value loaded on an accepted sync |
| sync_in | input | 1 | Sync pulse from a master instance |
| pwm_a | output | 1 | Channel A output (registered) |
| pwm_b | output | 1 | Channel B output (registered) |
| sync_out | output | 1 | One-cycle pulse following each counter zero |

## Verification
The bench measures low-cycle counts over whole triangles framed by sync pulses. A design that applies a compare immediately instead of at zero shows the new width one triangle too early. A design that lets the zero-point transfer take the value written in that same cycle misses the R6 check by one triangle. The top-value and zero-value compares are measured separately, because mishandling the turning point as a rising or falling match produces a stray edge and breaks the steady level. A master and slave pair started three cycles apart checks that the slave's sync input is ignored when phase loading is off. With phase loading on, the same pair must line up cycle for cycle; an off-by-one in the loaded counter value shifts the slave away from the master.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

  typedef enum logic [1:0] {
    AQ_HOLD = 2'd0,
    AQ_LOW  = 2'd1,
    AQ_HIGH = 2'd2,
    AQ_FLIP = 2'd3
  } aq_e;

  localparam int NCH     = 2;
  localparam int NREG    = 3;
  localparam int ADDR_W  = 2;
  localparam int CTL_W   = 9;
  localparam int PH_BIT  = 8;
  localparam int FLD_W   = 4;

  localparam logic [ADDR_W-1:0] ADR_TOP  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CMPA = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPB = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTL  = 2'd3;

  localparam logic [CTL_W-1:0] CTL_RST = 9'h099;

endpackage

// File: rtl/tri_pwm_regs.sv
module tri_pwm_regs
  import tri_pwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PER_RST = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              zero,
  output logic [CNT_W-1:0]  shd_q [NREG],
  output logic [CNT_W-1:0]  act_q [NREG],
  output logic [CTL_W-1:0]  ctl_q
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [CNT_W-1:0] RV = (g == 0) ? CNT_W'(PER_RST) : '0;
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(g);

    always_ff @(posedge clk) begin
      if (rst) begin
        shd_q[g] <= RV;
      end else if (wr_en && wr_addr == MY_ADR) begin
        shd_q[g] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[g] <= RV;
      end else if (zero) begin
        act_q[g] <= shd_q[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RST;
    end else if (wr_en && wr_addr == ADR_CTL) begin
      ctl_q <= wr_data[CTL_W-1:0];
    end
  end

endmodule

// File: rtl/tri_pwm_timebase.sv
module tri_pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] top,
  input  logic             load,
  input  logic [CNT_W-1:0] phase,
  output logic [CNT_W-1:0] cnt,
  output logic             zero,
  output logic             dn_eff
);

  logic going_up;
  logic at_top;

  assign zero   = (cnt == '0);
  assign at_top = (cnt >= top);

  // Direction seen by a match: the direction the counter leaves this value in.
  always_comb begin
    if (zero)        dn_eff = 1'b0;
    else if (at_top) dn_eff = 1'b1;
    else             dn_eff = ~going_up;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      going_up <= 1'b1;
    end else if (load) begin
      cnt      <= phase;
      going_up <= 1'b1;
    end else if (top == '0) begin
      cnt      <= '0;
      going_up <= 1'b1;
    end else if (going_up) begin
      if (at_top) begin
        cnt      <= cnt - 1'b1;
        going_up <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (zero) begin
        cnt      <= cnt + 1'b1;
        going_up <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/tri_pwm_aq.sv
module tri_pwm_aq
  import tri_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             dn_eff,
  input  aq_e              up_act,
  input  aq_e              dn_act,
  output logic             pwm
);

  logic hit;
  aq_e  sel;

  assign hit = (cnt == cmp);
  assign sel = dn_eff ? dn_act : up_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm <= 1'b0;
    end else if (hit) begin
      case (sel)
        AQ_LOW:  pwm <= 1'b0;
        AQ_HIGH: pwm <= 1'b1;
        AQ_FLIP: pwm <= ~pwm;
        default: pwm <= pwm;
      endcase
    end
  end

endmodule

// File: rtl/tri_pwm.sv
module tri_pwm
  import tri_pwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PER_RST = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [CNT_W-1:0]  phase_val,
  input  logic              sync_in,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              sync_out
);

  logic [CNT_W-1:0] shd_q [NREG];
  logic [CNT_W-1:0] act_q [NREG];
  logic [CTL_W-1:0] ctl_q;
  logic [CNT_W-1:0] cnt;
  logic             zero;
  logic             dn_eff;
  logic             load;
  logic [NCH-1:0]   pwm_w;

  assign load = sync_in & ctl_q[PH_BIT];

  tri_pwm_regs #(.CNT_W(CNT_W), .PER_RST(PER_RST)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .zero    (zero),
    .shd_q   (shd_q),
    .act_q   (act_q),
    .ctl_q   (ctl_q)
  );

  tri_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .top    (act_q[0]),
    .load   (load),
    .phase  (phase_val),
    .cnt    (cnt),
    .zero   (zero),
    .dn_eff (dn_eff)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int B = ch * FLD_W;
    aq_e up_act;
    aq_e dn_act;

    assign up_act = aq_e'(ctl_q[B +: 2]);
    assign dn_act = aq_e'(ctl_q[B+2 +: 2]);

    tri_pwm_aq #(.CNT_W(CNT_W)) u_aq (
      .clk    (clk),
      .rst    (rst),
      .cnt    (cnt),
      .cmp    (act_q[ch+1]),
      .dn_eff (dn_eff),
      .up_act (up_act),
      .dn_act (dn_act),
      .pwm    (pwm_w[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sync_out <= 1'b0;
    else     sync_out <= zero;
  end

  assign pwm_a = pwm_w[0];
  assign pwm_b = pwm_w[1];

endmodule

// File: rtl/tri_pwm_checks.sv
module tri_pwm_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic             zero,
  input logic             load,
  input logic [CNT_W-1:0] top_a,
  input logic [CNT_W-1:0] cmpa_a,
  input logic [CNT_W-1:0] cmpb_a,
  input logic [CNT_W-1:0] top_s,
  input logic [CNT_W-1:0] cmpa_s,
  input logic [CNT_W-1:0] cmpb_s,
  input logic             pwm_a,
  input logic             pwm_b
);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !zero |=> ($stable(top_a) && $stable(cmpa_a) && $stable(cmpb_a)));

  assert_transfer_R2: assert property (@(posedge clk) disable iff (rst)
    zero |=> (top_a == $past(top_s) && cmpa_a == $past(cmpa_s) && cmpb_a == $past(cmpb_s)));

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && $past(top_a) != '0)
      |-> (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

  assert_range_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && top_a != '0 && $past(cnt) <= $past(top_a))
      |-> (cnt <= top_a));

  assert_edge_a_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pwm_a != $past(pwm_a)) |-> ($past(cnt) == $past(cmpa_a)));

  assert_edge_b_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pwm_b != $past(pwm_b)) |-> ($past(cnt) == $past(cmpb_a)));

endmodule

bind tri_pwm tri_pwm_checks #(.CNT_W(CNT_W)) u_checks (
  .clk    (clk),
  .rst    (rst),
  .cnt    (cnt),
  .zero   (zero),
  .load   (load),
  .top_a  (act_q[0]),
  .cmpa_a (act_q[1]),
  .cmpb_a (act_q[2]),
  .top_s  (shd_q[0]),
  .cmpa_s (shd_q[1]),
  .cmpb_s (shd_q[2]),
  .pwm_a  (pwm_a),
  .pwm_b  (pwm_b)
);

// File: tb/test_tri_pwm.sv
`timescale 1ns/1ps
module test_tri_pwm;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_s = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic pwm_a, pwm_b, m_sync;
  logic s_pwm_a, s_pwm_b, s_sync;

  int checks = 0;
  int fails = 0;
  int cur_per = 10;

  always #2.5 clk = ~clk;

  tri_pwm #(.CNT_W(CNT_W), .PER_RST(10)) i_tri_pwm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phase_val(16'd0), .sync_in(1'b0),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .sync_out(m_sync)
  );

  tri_pwm #(.CNT_W(CNT_W), .PER_RST(10)) i_tri_pwm_slave (
    .clk(clk), .rst(rst_s), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phase_val(16'd2), .sync_in(m_sync),
    .pwm_a(s_pwm_a), .pwm_b(s_pwm_b), .sync_out(s_sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_at();
    while (!m_sync) @(negedge clk);
  endtask

  // Counts low cycles over one triangle; optionally writes at cycle index wat.
  task automatic measure_w(input int wat, input logic [1:0] a, input int d,
                           output int la, output int lb);
    sync_at();
    la = 0; lb = 0;
    for (int i = 0; i < 2 * cur_per; i++) begin
      if (i == wat) begin wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d); end
      else wr_en = 1'b0;
      if (!pwm_a) la++;
      if (!pwm_b) lb++;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic measure(output int la, output int lb);
    measure_w(-1, 2'd0, 0, la, lb);
  endtask

  task automatic settle(output int la, output int lb);
    for (int k = 0; k < 3; k++) measure(la, lb);
  endtask

  task automatic sync_gap(output int n);
    sync_at();
    n = 0;
    do begin @(negedge clk); n++; end while (!m_sync);
  endtask

  task automatic t_reset();
    int n, la, lb;
    rst = 1'b1; rst_s = 1'b1;
    repeat (4) @(negedge clk);
    chk(pwm_a == 1'b0, "R8 pwm_a in reset", pwm_a, 0);
    chk(pwm_b == 1'b0, "R8 pwm_b in reset", pwm_b, 0);
    chk(m_sync == 1'b0, "R8 sync_out in reset", m_sync, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    rst_s = 1'b0;
    sync_gap(n);
    chk(n == 20, "R1 R8 sync interval with reset top", n, 20);
    measure(la, lb);
    chk(la == 20, "R8 R5 reset compare A zero keeps low", la, 20);
    chk(lb == 20, "R8 R5 reset compare B zero keeps low", lb, 20);
  endtask

  task automatic t_phase();
    int la, lb, both, sc, mis;
    wr(2'd1, 4);
    settle(la, lb);
    both = 0; sc = 0;
    for (int i = 0; i < 40; i++) begin
      if (m_sync && s_sync) both++;
      if (s_sync) sc++;
      @(negedge clk);
    end
    chk(both == 0, "R11 slave ignores sync when load disabled", both, 0);
    chk(sc == 2, "R11 slave keeps own triangle", sc, 2);
    wr(2'd3, 'h199);
    settle(la, lb);
    mis = 0;
    for (int i = 0; i < 40; i++) begin
      if (m_sync != s_sync) mis++;
      if (pwm_a != s_pwm_a) mis++;
      @(negedge clk);
    end
    chk(mis == 0, "R10 slave aligned to master with phase 2", mis, 0);
    wr(2'd3, 'h099);
  endtask

  task automatic t_duty();
    int la, lb;
    wr(2'd1, 3); wr(2'd2, 7);
    settle(la, lb);
    chk(la == 14, "R4 compare 3 low cycles", la, 14);
    chk(lb == 6, "R4 compare 7 low cycles", lb, 6);
    wr(2'd1, 10); wr(2'd2, 0);
    settle(la, lb);
    chk(la == 0, "R5 compare equal top stays high", la, 0);
    chk(lb == 20, "R5 compare zero stays low", lb, 20);
  endtask

  task automatic t_shadow();
    int la, lb;
    wr(2'd1, 3);
    settle(la, lb);
    measure_w(5, 2'd1, 8, la, lb);
    chk(la == 14, "R3 mid-triangle write leaves current pulse", la, 14);
    measure(la, lb);
    chk(la == 4, "R2 new compare after zero", la, 4);
    measure_w(2 * cur_per - 1, 2'd1, 2, la, lb);
    chk(la == 4, "R6 triangle before zero write", la, 4);
    measure(la, lb);
    chk(la == 4, "R6 zero-cycle write held one triangle", la, 4);
    measure(la, lb);
    chk(la == 16, "R6 zero-cycle write applied later", la, 16);
  endtask

  task automatic t_period();
    int la, lb, n;
    measure_w(6, 2'd0, 6, la, lb);
    chk(la == 16, "R7 current triangle keeps old top", la, 16);
    n = 0;
    do begin @(negedge clk); n++; end while (!m_sync);
    chk(n == 12, "R7 next triangle uses new top", n, 12);
    cur_per = 6;
    settle(la, lb);
    chk(la == 8, "R7 R4 duty at new top", la, 8);
  endtask

  task automatic t_actions();
    int la, lb;
    wr(2'd3, 'h096);
    settle(la, lb);
    chk(la == 4, "R9 inverted actions on A", la, 4);
    chk(lb == 12, "R9 default actions on B", lb, 12);
    wr(2'd2, 3);
    wr(2'd3, 'h0F6);
    settle(la, lb);
    chk(lb == 6, "R9 toggle actions on B", lb, 6);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_phase();
    t_duty();
    t_shadow();
    t_period();
    t_actions();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule